// File: doc/BRIEF.md
# Multiplexed Switch and LED Scanner

This block serves the second half of a time-shared matrix scan. The row-select lines and two 11-bit column buses are shared with a keyboard scanner. An external phase signal marks which scanner owns them: high for the keyboard, low for this block. In every low phase the block looks at a single row. It takes one sample of the switch column bus for that row and drives the LED column bus for the same row. The row index moves on by one each time the phase returns to the keyboard.

The switch matrix has 16 rows × 11 columns, with one series diode per switch. A new switch state is accepted only when the same value has been read for that row on two consecutive full scans. An accepted change updates a status memory and raises a one-cycle event for the host. The event carries the row and a mask of the columns that changed. The host then reads the accepted state through a combinational read port.

The host writes LED on/off states for rows 0 to 7 into a small memory. The block refreshes the LEDs without further host action. In each low phase it holds the LED bus undriven for a guard interval after the row change. It releases the bus one cycle after the phase returns high. Rows 8 to 15 never drive the LED bus.

Top module: `swled_scan`

## Requirements
- R1: After reset `led_oe` is 0, `led_out` is 0, `sw_evt` is 0, `scan_row` is 0 and every row of the switch status memory reads 0.
- R2: `scan_row` holds constant during a low phase of `kbd_phase`. It advances by one at the first clock edge that samples `kbd_phase` high after a low phase, wrapping from ROWS-1 to 0. The first high phase after reset does not advance it.
- R3: `sw_in` is sampled exactly once per low phase, at the (SAMPLE_AT+1)-th rising edge that samples `kbd_phase` low. Any event appears one cycle after that edge and lasts one cycle.
- R4: A column of a row is accepted into the status memory only when the new value was read in both the previous scan and the current scan of that row. A value seen on a single scan produces no event and leaves the status unchanged.
- R5: On acceptance, `sw_evt` pulses for one cycle. `sw_evt_row` gives the row and `sw_evt_mask` has a 1 for every column that changed in either direction. From that cycle on, `host_sw` shows the new row state while `host_row` selects that row. Bit i of `sw_in`, `host_sw` and the mask is column i, and 1 means closed.
- R6: A write with `led_we`=1 stores `led_wdata` for LED row `led_waddr` (0 to LED_ROWS-1). While that row is driven, `led_out[i]` equals bit i of the stored word.
- R7: `led_oe` is 1 only inside a low phase. It rises after the (GUARD+1)-th edge that samples `kbd_phase` low and is 0 after every edge that samples `kbd_phase` high. `led_out` is 0 whenever `led_oe` is 0.
- R8: While `scan_row` is LED_ROWS or above, `led_oe` stays 0 for the whole low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kbd_phase | input | 1 | Bus owner: 1 keyboard, 0 this block |
| sw_in | input | COLS | Switch column bus, 1 = closed |
| scan_row | output | ROW_W | Row selected for the current/next low phase |
| led_out | output | COLS | LED column data |
| led_oe | output | 1 | LED bus drive enable |
| led_we | input | 1 | Host LED memory write strobe |
| led_waddr | input | LED_AW | Host LED row address |
| led_wdata | input | COLS | Host LED row on/off states |
| host_row | input | ROW_W | Row to read from the switch status memory |
| host_sw | output | COLS | Accepted switch state of `host_row` |
| sw_evt | output | 1 | One-cycle switch change event |
| sw_evt_row | output | ROW_W | Row of the last event |
| sw_evt_mask | output | COLS | Columns changed in the last event |

## Verification
The properties assume that `kbd_phase` is synchronous to `clk`. They also assume every low phase lasts longer than both SAMPLE_AT+1 and GUARD+1 edges, so each low phase contains exactly one sample point and one drive window. They further assume that `sw_in` changes only while the keyboard owns the buses, and that `host_row` and `led_waddr` stay within their row ranges. The stimulus drives every input on falling clock edges. It uses 12-cycle high and 40-cycle low phases, changes `sw_in` only at the start of a high phase and keeps all addresses in range.

// File: rtl/swled_pkg.sv
package swled_pkg;
    localparam int DEF_COLS      = 11;
    localparam int DEF_ROWS      = 16;
    localparam int DEF_LED_ROWS  = 8;
    localparam int DEF_GUARD     = 8;
    localparam int DEF_SAMPLE_AT = 16;
    localparam int DEF_CNT_W     = 8;
endpackage

// File: rtl/swled_seq.sv
module swled_seq #(
    parameter int ROWS      = swled_pkg::DEF_ROWS,
    parameter int LED_ROWS  = swled_pkg::DEF_LED_ROWS,
    parameter int GUARD     = swled_pkg::DEF_GUARD,
    parameter int SAMPLE_AT = swled_pkg::DEF_SAMPLE_AT,
    parameter int CNT_W     = swled_pkg::DEF_CNT_W,
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kbd_phase,
    output logic [ROW_W-1:0] row,
    output logic             sample_stb,
    output logic             drive_nxt
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [CNT_W-1:0] GUARD_C  = CNT_W'(GUARD);
    localparam logic [CNT_W-1:0] SAMP_C   = CNT_W'(SAMPLE_AT);
    localparam logic [ROW_W:0]   LED_LIM  = (ROW_W + 1)'(LED_ROWS);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
        logic             was_lo;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.was_lo = !kbd_phase;
        if (kbd_phase) begin
            s_d.cnt = '0;
            if (s_q.was_lo) begin
                s_d.row = (s_q.row == LAST_ROW) ? '0 : s_q.row + 1'b1;
            end
        end else if (s_q.cnt != '1) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        sample_stb = !kbd_phase && (s_q.cnt == SAMP_C);
        drive_nxt  = !kbd_phase && (s_q.cnt >= GUARD_C) && ({1'b0, s_q.row} < LED_LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign row = s_q.row;
endmodule

// File: rtl/swled_debounce.sv
module swled_debounce #(
    parameter int COLS   = swled_pkg::DEF_COLS,
    parameter int ROWS   = swled_pkg::DEF_ROWS,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic [ROW_W-1:0] row,
    input  logic [COLS-1:0]  sw_in,
    input  logic [ROW_W-1:0] host_row,
    output logic [COLS-1:0]  host_sw,
    output logic             evt,
    output logic [ROW_W-1:0] evt_row,
    output logic [COLS-1:0]  evt_mask
);
    typedef struct packed {
        logic [ROWS-1:0][COLS-1:0] prev;
        logic [ROWS-1:0][COLS-1:0] stable;
        logic                      evt;
        logic [ROW_W-1:0]          evt_row;
        logic [COLS-1:0]           evt_mask;
    } deb_t;

    deb_t s_d, s_q;
    logic [COLS-1:0] raw;
    logic [COLS-1:0] old_raw;
    logic [COLS-1:0] old_acc;

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        raw     = sw_in;
        old_raw = s_q.prev[row];
        old_acc = s_q.stable[row];
        if (sample_stb) begin
            s_d.prev[row] = raw;
            if ((raw == old_raw) && (raw != old_acc)) begin
                s_d.stable[row] = raw;
                s_d.evt         = 1'b1;
                s_d.evt_row     = row;
                s_d.evt_mask    = raw ^ old_acc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign host_sw  = s_q.stable[host_row];
    assign evt      = s_q.evt;
    assign evt_row  = s_q.evt_row;
    assign evt_mask = s_q.evt_mask;
endmodule

// File: rtl/swled_led.sv
module swled_led #(
    parameter int COLS     = swled_pkg::DEF_COLS,
    parameter int LED_ROWS = swled_pkg::DEF_LED_ROWS,
    localparam int LED_AW  = (LED_ROWS > 1) ? $clog2(LED_ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LED_AW-1:0] waddr,
    input  logic [COLS-1:0]   wdata,
    input  logic [LED_AW-1:0] row,
    input  logic              drive_nxt,
    output logic [COLS-1:0]   led_out,
    output logic              led_oe
);
    typedef struct packed {
        logic [LED_ROWS-1:0][COLS-1:0] mem;
        logic                          oe;
        logic [COLS-1:0]               data;
    } led_t;

    led_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.mem[waddr] = wdata;
        end
        s_d.oe   = drive_nxt;
        s_d.data = drive_nxt ? s_q.mem[row] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign led_out = s_q.data;
    assign led_oe  = s_q.oe;
endmodule

// File: rtl/swled_scan.sv
module swled_scan #(
    parameter int COLS      = swled_pkg::DEF_COLS,
    parameter int ROWS      = swled_pkg::DEF_ROWS,
    parameter int LED_ROWS  = swled_pkg::DEF_LED_ROWS,
    parameter int GUARD     = swled_pkg::DEF_GUARD,
    parameter int SAMPLE_AT = swled_pkg::DEF_SAMPLE_AT,
    parameter int CNT_W     = swled_pkg::DEF_CNT_W,
    localparam int ROW_W    = $clog2(ROWS),
    localparam int LED_AW   = (LED_ROWS > 1) ? $clog2(LED_ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_phase,
    input  logic [COLS-1:0]   sw_in,
    output logic [ROW_W-1:0]  scan_row,
    output logic [COLS-1:0]   led_out,
    output logic              led_oe,
    input  logic              led_we,
    input  logic [LED_AW-1:0] led_waddr,
    input  logic [COLS-1:0]   led_wdata,
    input  logic [ROW_W-1:0]  host_row,
    output logic [COLS-1:0]   host_sw,
    output logic              sw_evt,
    output logic [ROW_W-1:0]  sw_evt_row,
    output logic [COLS-1:0]   sw_evt_mask
);
    logic             sample_stb;
    logic             drive_nxt;
    logic [ROW_W-1:0] row;

    swled_seq #(
        .ROWS(ROWS), .LED_ROWS(LED_ROWS), .GUARD(GUARD),
        .SAMPLE_AT(SAMPLE_AT), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .kbd_phase(kbd_phase),
        .row(row), .sample_stb(sample_stb), .drive_nxt(drive_nxt)
    );

    swled_debounce #(.COLS(COLS), .ROWS(ROWS)) u_deb (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .row(row),
        .sw_in(sw_in), .host_row(host_row), .host_sw(host_sw),
        .evt(sw_evt), .evt_row(sw_evt_row), .evt_mask(sw_evt_mask)
    );

    swled_led #(.COLS(COLS), .LED_ROWS(LED_ROWS)) u_led (
        .clk(clk), .rst_n(rst_n), .we(led_we), .waddr(led_waddr),
        .wdata(led_wdata), .row(row[LED_AW-1:0]), .drive_nxt(drive_nxt),
        .led_out(led_out), .led_oe(led_oe)
    );

    assign scan_row = row;
endmodule

// File: rtl/swled_scan_chk.sv
module swled_scan_chk #(
    parameter int COLS     = 11,
    parameter int ROWS     = 16,
    parameter int LED_ROWS = 8,
    localparam int ROW_W   = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             kbd_phase,
    input logic [ROW_W-1:0] scan_row,
    input logic [COLS-1:0]  led_out,
    input logic             led_oe,
    input logic             sw_evt,
    input logic [COLS-1:0]  sw_evt_mask
);
    localparam logic [ROW_W:0] LED_LIM = (ROW_W + 1)'(LED_ROWS);

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !kbd_phase |=> $stable(scan_row)); // R2
    AST_OE_OFF_KBD: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_phase |=> !led_oe); // R7
    AST_OE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kbd_phase) |=> !led_oe); // R7
    AST_LED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !led_oe |-> (led_out == '0)); // R7
    AST_LED_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        led_oe |-> ({1'b0, scan_row} < LED_LIM)); // R8
    AST_EVT_IN_LO: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |-> $past(!kbd_phase)); // R3
    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |=> !sw_evt); // R3
    AST_EVT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |-> (sw_evt_mask != '0)); // R5
endmodule

bind swled_scan swled_scan_chk #(.COLS(COLS), .ROWS(ROWS), .LED_ROWS(LED_ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .kbd_phase(kbd_phase), .scan_row(scan_row),
    .led_out(led_out), .led_oe(led_oe), .sw_evt(sw_evt), .sw_evt_mask(sw_evt_mask)
);

// File: tb/swled_scan_tb.sv
module swled_scan_tb;
    localparam int COLS = 11, ROWS = 16, LROWS = 8, GUARD = 8, SAMP = 16;
    localparam int HI = 12, LO = 40;

    logic clk = 1'b0, rst_n = 1'b0, kbd_phase = 1'b1;
    logic [COLS-1:0] sw_in = '0, led_out, led_wdata = '0, host_sw, sw_evt_mask;
    logic [3:0] scan_row, host_row = '0, sw_evt_row;
    logic [2:0] led_waddr = '0;
    logic led_oe, led_we = 1'b0, sw_evt;

    int n_chk = 0, n_bad = 0;
    logic [COLS-1:0] sw_pat [ROWS];
    logic [COLS-1:0] exp_prev [ROWS];
    logic [COLS-1:0] exp_acc [ROWS];
    logic [COLS-1:0] led_model [LROWS];
    int model_row = 0;
    bit first_done = 0;

    swled_scan u_dut (
        .clk(clk), .rst_n(rst_n), .kbd_phase(kbd_phase), .sw_in(sw_in),
        .scan_row(scan_row), .led_out(led_out), .led_oe(led_oe),
        .led_we(led_we), .led_waddr(led_waddr), .led_wdata(led_wdata),
        .host_row(host_row), .host_sw(host_sw), .sw_evt(sw_evt),
        .sw_evt_row(sw_evt_row), .sw_evt_mask(sw_evt_mask)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic led_write(input int r, input logic [COLS-1:0] d);
        @(negedge clk);
        led_we = 1'b1; led_waddr = 3'(r); led_wdata = d;
        @(negedge clk);
        led_we = 1'b0;
        led_model[r] = d;
    endtask

    // One keyboard phase followed by one switch/LED phase, checked against the model.
    task automatic phase_cycle();
        bit hi_bad = 0, row_bad = 0;
        int evt_n = 0, exp_n = 0;
        logic [COLS-1:0] em = '0, exp_mask = '0, raw;
        logic [3:0] er = '0;
        if (first_done) model_row = (model_row + 1) % ROWS;
        first_done = 1;
        kbd_phase = 1'b1;
        sw_in = sw_pat[model_row];
        for (int j = 1; j <= HI; j++) begin
            @(negedge clk);
            if (led_oe !== 1'b0 || led_out !== '0) hi_bad = 1;
        end
        check("R7", "bus released in keyboard phase", 32'(hi_bad), 0);
        check("R2", "row index", 32'(scan_row), 32'(model_row));
        raw = sw_pat[model_row];
        if (raw == exp_prev[model_row] && raw != exp_acc[model_row]) begin
            exp_n = 1;
            exp_mask = raw ^ exp_acc[model_row];
            exp_acc[model_row] = raw;
        end
        exp_prev[model_row] = raw;
        kbd_phase = 1'b0;
        for (int j = 1; j <= LO; j++) begin
            @(negedge clk);
            if (j == GUARD) check("R7", "guard keeps bus off", 32'(led_oe), 0);
            if (j == GUARD + 1) begin
                check("R8", "drive enable by row", 32'(led_oe), 32'(model_row < LROWS));
                check("R6", "led column data", 32'(led_out),
                      (model_row < LROWS) ? 32'(led_model[model_row]) : 0);
            end
            if (sw_evt) begin
                evt_n++; er = sw_evt_row; em = sw_evt_mask;
                check("R3", "event one cycle after sample", 32'(j), SAMP + 1);
            end
            if (scan_row !== 4'(model_row)) row_bad = 1;
        end
        check("R2", "row constant in low phase", 32'(row_bad), 0);
        check("R4", "event count", 32'(evt_n), 32'(exp_n));
        if (exp_n == 1 && evt_n == 1) begin
            check("R5", "event row", 32'(er), 32'(model_row));
            check("R5", "event mask", 32'(em), 32'(exp_mask));
        end
        host_row = 4'(model_row);
        #1;
        check("R5", "status readback", 32'(host_sw), 32'(exp_acc[model_row]));
    endtask

    task automatic run_phases(input int n);
        for (int i = 0; i < n; i++) phase_cycle();
    endtask

    task automatic t_reset();
        check("R1", "led_oe", 32'(led_oe), 0);
        check("R1", "led_out", 32'(led_out), 0);
        check("R1", "sw_evt", 32'(sw_evt), 0);
        check("R1", "scan_row", 32'(scan_row), 0);
        for (int r = 0; r < ROWS; r++) begin
            host_row = 4'(r);
            #1;
            check("R1", "status row", 32'(host_sw), 0);
        end
    endtask

    task automatic t_led_refresh();
        for (int r = 0; r < LROWS; r++) led_write(r, (11'h400 >> r) | 11'(r));
        run_phases(18); // covers rows 8..15 and the wrap to 0 (R2, R8)
    endtask

    task automatic t_switch_confirm();
        sw_pat[3] = 11'h005;
        run_phases(16); // first sighting only: no event (R4)
        run_phases(16); // confirmed: event row 3 mask 005 (R5)
        check("R5", "row 3 accepted", 32'(exp_acc[3]), 32'h005);
    endtask

    task automatic t_glitch();
        sw_pat[5] = 11'h200;
        run_phases(16);
        sw_pat[5] = 11'h000;
        run_phases(16);
        host_row = 4'd5;
        #1;
        check("R4", "single-scan glitch ignored", 32'(host_sw), 0);
    endtask

    task automatic t_release_and_edges();
        sw_pat[3]  = 11'h000;
        sw_pat[15] = 11'h400;
        sw_pat[0]  = 11'h7FF;
        run_phases(32);
        host_row = 4'd15;
        #1;
        check("R5", "last row, top column", 32'(host_sw), 32'h400);
    endtask

    task automatic t_led_update();
        led_write(2, 11'h2AA);
        led_write(7, 11'h000);
        run_phases(16);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            sw_pat[r] = '0; exp_prev[r] = '0; exp_acc[r] = '0;
        end
        for (int r = 0; r < LROWS; r++) led_model[r] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_led_refresh();
        t_switch_confirm();
        t_glitch();
        t_release_and_edges();
        t_led_update();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule